// File: doc/BRIEF.md
# Power-Fail Gated Memory Decoder

This block sits between a host bus and two targets: a bank of 64 on-chip registers and an external static RAM. It splits a 17-bit host address into two windows. The low window steers the host chip enable to a register select with a 6-bit register index. The rest of the space drives an active-low chip enable for the external RAM. It also gates the host read-data drivers and forms a register write strobe. That strobe ends on the first rising edge of either the chip enable or the write enable.

A digital power-good input is brought into the clock domain through two flops. While power is reported bad, the block blocks every access and raises a power-fail flag. When power comes back, a down-counter keeps the block locked for a set hold-off time. The hold-off is set by the clock rate in kHz and the time in ms. If power drops again during the hold-off, the full window starts over.

Top module: `pf_mem_gate`

## Requirements
- R1: With the chip enable low, protection off and an address from 0x00000 to 0x0003F, `reg_cs_n` is low and `ram_ce_n` is high. `reg_idx` always equals address bits [5:0].
- R2: With the chip enable low, protection off and an address from 0x00040 to 0x1FFFF, `ram_ce_n` is low and `reg_cs_n` is high.
- R3: With `ce_n` high, `reg_cs_n` and `ram_ce_n` are both high and `dout_en` is low, whatever the address, `we_n` and `oe_n`.
- R4: While protection is active, `reg_cs_n` and `ram_ce_n` are both high and `dout_en` is low, for any address and control levels.
- R5: A low level on `pwr_good` raises `pfail` at the second rising clock edge that samples it. After the first such edge, access still works.
- R6: After `pwr_good` returns high, `pfail` and the access block stay in force. They lift at rising edge number HOLD_CYC+2, where HOLD_CYC = CLK_KHZ*HOLD_MS and edges are counted from the first edge that samples `pwr_good` high.
- R7: If `pwr_good` drops during the hold-off, the hold-off restarts in full. Release again comes HOLD_CYC+2 edges after `pwr_good` is sampled high again.
- R8: `dout_en` is high only when `ce_n` is low, `oe_n` is low, `we_n` is high and protection is off. A low `we_n` forces `dout_en` low even while `ce_n` and `oe_n` are low.
- R9: `reg_wr_n` is low only while `reg_cs_n` is low and `we_n` is low. It rises on whichever of `ce_n` or `we_n` rises first. It stays high for RAM addresses.
- R10: While `rst_n` is low, `pfail` is high and both selects are high, even with `pwr_good` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 17 | Host address |
| ce_n | input | 1 | Host chip enable, active low |
| we_n | input | 1 | Host write enable, active low |
| oe_n | input | 1 | Host output enable, active low |
| pwr_good | input | 1 | Supply in tolerance (asynchronous) |
| reg_cs_n | output | 1 | On-chip register select, active low |
| reg_idx | output | 6 | Register index |
| reg_wr_n | output | 1 | Register write strobe, active low; write is taken at its rising edge |
| ram_ce_n | output | 1 | External RAM chip enable, active low |
| dout_en | output | 1 | Read-data driver enable, active high |
| pfail | output | 1 | Power-fail flag, high while protected |

## Verification
The bench builds the block with CLK_KHZ=2 and HOLD_MS=150, which gives a 300-cycle hold-off. That is short enough to measure the release edge to the exact cycle, both after reset and after a dropout that restarts the window partway through. The address width and register count stay at their defaults. This keeps the boundary addresses 0x3F/0x40 and the top of the space 0x1FFFF within the vector table.

// File: rtl/pfgate_pkg.sv
package pfgate_pkg;

  // Which target a host access resolves to
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_REG  = 2'd1,
    TGT_RAM  = 2'd2
  } tgt_e;

  localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/pfgate_sync.sv
module pfgate_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/pfgate_holdoff.sv
module pfgate_holdoff #(
  parameter int unsigned HOLD_CYC = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pg_ok,
  output logic protect
);

  localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(HOLD_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             busy;

  assign busy = (cnt_q != '0);

  always_comb begin
    cnt_en = !pg_ok || busy;
    if (!pg_ok) cnt_d = LOAD_VAL;
    else        cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= LOAD_VAL;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign protect = !pg_ok || busy;

  AST_RELOAD_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_ok |=> (cnt_q == LOAD_VAL)); // R7

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_ok && busy) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_ok && !busy) |=> !protect || !pg_ok); // R6

endmodule

// File: rtl/pfgate_decode.sv
module pfgate_decode
  import pfgate_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned REG_AW = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              protect,
  output logic              reg_cs_n,
  output logic [REG_AW-1:0] reg_idx,
  output logic              reg_wr_n,
  output logic              ram_ce_n,
  output logic              dout_en
);

  logic in_reg_win;
  logic access_ok;
  tgt_e tgt;

  assign in_reg_win = (addr[ADDR_W-1:REG_AW] == '0);
  assign access_ok  = !ce_n && !protect;

  always_comb begin
    if (!access_ok)      tgt = TGT_NONE;
    else if (in_reg_win) tgt = TGT_REG;
    else                 tgt = TGT_RAM;
  end

  assign reg_idx  = addr[REG_AW-1:0];
  assign reg_cs_n = (tgt != TGT_REG);
  assign ram_ce_n = (tgt != TGT_RAM);
  assign reg_wr_n = !((tgt == TGT_REG) && !we_n);
  assign dout_en  = access_ok && !oe_n && we_n;

endmodule

// File: rtl/pf_mem_gate.sv
module pf_mem_gate
  import pfgate_pkg::*;
#(
  parameter int unsigned ADDR_W  = 17,
  parameter int unsigned REG_AW  = 6,
  parameter int unsigned CLK_KHZ = 250000,
  parameter int unsigned HOLD_MS = 150
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              pwr_good,
  output logic              reg_cs_n,
  output logic [REG_AW-1:0] reg_idx,
  output logic              reg_wr_n,
  output logic              ram_ce_n,
  output logic              dout_en,
  output logic              pfail
);

  localparam int unsigned HOLD_CYC  = CLK_KHZ * HOLD_MS;
  localparam int unsigned REG_COUNT = 1 << REG_AW;

  logic pg_s;
  logic protect;

  pfgate_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pwr_good),
    .dout (pg_s)
  );

  pfgate_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .pg_ok  (pg_s),
    .protect(protect)
  );

  pfgate_decode #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_dec (
    .addr    (addr),
    .ce_n    (ce_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .protect (protect),
    .reg_cs_n(reg_cs_n),
    .reg_idx (reg_idx),
    .reg_wr_n(reg_wr_n),
    .ram_ce_n(ram_ce_n),
    .dout_en (dout_en)
  );

  assign pfail = protect;

  AST_PROT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    pfail |-> (reg_cs_n && ram_ce_n && !dout_en)); // R4

  AST_LOSS_PROTECTS: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_s |-> pfail); // R5

  AST_WE_KILLS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !dout_en); // R8

  AST_REG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_cs_n |-> (addr < ADDR_W'(REG_COUNT))); // R1

  AST_RAM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_ce_n |-> (addr >= ADDR_W'(REG_COUNT))); // R2

  AST_CE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (reg_cs_n && ram_ce_n && !dout_en)); // R3

  AST_WR_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_n |-> (!reg_cs_n && !we_n)); // R9

endmodule

// File: tb/pf_mem_gate_bench.sv
module pf_mem_gate_bench;

  localparam int unsigned CLK_KHZ = 2;
  localparam int unsigned HOLD_MS = 150;
  localparam int unsigned HOLD_CYC = CLK_KHZ * HOLD_MS;
  localparam int unsigned REL_EDGE = HOLD_CYC + 2;

  typedef struct packed {
    logic [16:0] a;
    logic        ce;
    logic        we;
    logic        oe;
    logic        x_cs;
    logic        x_ram;
    logic        x_den;
    logic        x_wr;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{17'h00000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R1 R8 lowest reg, read
    '{17'h0003F, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}, // R1 top reg, OE off
    '{17'h00040, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R2 first RAM addr
    '{17'h1FFFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R2 R9 RAM write, no reg strobe
    '{17'h00025, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R9 reg write
    '{17'h00025, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R8 WE low overrides OE
    '{17'h00010, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1}, // R3 CE high, reg addr
    '{17'h12345, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1}, // R3 CE high, RAM addr
    '{17'h0ABCD, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R2 R8 RAM read
    '{17'h0FFC0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}  // R2 low bits zero, high bits set
  };

  logic        clk;
  logic        rst_n;
  logic [16:0] addr;
  logic        ce_n, we_n, oe_n, pwr_good;
  logic        reg_cs_n, reg_wr_n, ram_ce_n, dout_en, pfail;
  logic [5:0]  reg_idx;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  pf_mem_gate #(.CLK_KHZ(CLK_KHZ), .HOLD_MS(HOLD_MS)) u_pf_mem_gate (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .pwr_good(pwr_good), .reg_cs_n(reg_cs_n), .reg_idx(reg_idx),
    .reg_wr_n(reg_wr_n), .ram_ce_n(ram_ce_n), .dout_en(dout_en), .pfail(pfail)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [16:0] a, input logic c, input logic w,
                       input logic o);
    @(negedge clk);
    addr = a; ce_n = c; we_n = w; oe_n = o;
    #1;
  endtask

  // Counts rising edges until pfail drops; edge 1 is the next one
  task automatic edges_to_release(output int n);
    n = 0;
    do begin
      @(posedge clk);
      #1;
      n++;
      if (n == 10) check("R6", "ram_ce_n blocked in hold-off", int'(ram_ce_n), 1);
    end while (pfail && n < int'(REL_EDGE) + 50);
  endtask

  initial begin
    int n;
    rst_n = 1'b0; addr = 17'h00040; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
    pwr_good = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R10", "pfail in reset", int'(pfail), 1);
    check("R10", "ram_ce_n in reset", int'(ram_ce_n), 1);
    check("R10", "reg_cs_n in reset", int'(reg_cs_n), 1);
    check("R10", "dout_en in reset", int'(dout_en), 0);

    @(negedge clk);
    rst_n = 1'b1;
    edges_to_release(n);
    check("R6", "release edge after reset", n, int'(REL_EDGE));

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].a, VEC[i].ce, VEC[i].we, VEC[i].oe);
      check("R1/R2/R3", $sformatf("vec%0d reg_cs_n", i), int'(reg_cs_n), int'(VEC[i].x_cs));
      check("R1/R2/R3", $sformatf("vec%0d ram_ce_n", i), int'(ram_ce_n), int'(VEC[i].x_ram));
      check("R8", $sformatf("vec%0d dout_en", i), int'(dout_en), int'(VEC[i].x_den));
      check("R9", $sformatf("vec%0d reg_wr_n", i), int'(reg_wr_n), int'(VEC[i].x_wr));
      check("R1", $sformatf("vec%0d reg_idx", i), int'(reg_idx), int'(VEC[i].a[5:0]));
    end

    // R9: WE rises first
    drive(17'h00005, 1'b0, 1'b0, 1'b1);
    check("R9", "strobe low in write", int'(reg_wr_n), 0);
    drive(17'h00005, 1'b0, 1'b1, 1'b1);
    check("R9", "strobe ends on WE rise", int'(reg_wr_n), 1);
    // R9: CE rises first
    drive(17'h00005, 1'b0, 1'b0, 1'b1);
    check("R9", "strobe low again", int'(reg_wr_n), 0);
    drive(17'h00005, 1'b1, 1'b0, 1'b1);
    check("R9", "strobe ends on CE rise", int'(reg_wr_n), 1);
    drive(17'h00005, 1'b1, 1'b1, 1'b1);
    check("R9", "strobe stays high", int'(reg_wr_n), 1);

    // R5 / R4: power loss
    drive(17'h00040, 1'b0, 1'b1, 1'b0);
    pwr_good = 1'b0;
    @(posedge clk); #1;
    check("R5", "pfail after 1 edge", int'(pfail), 0);
    check("R5", "ram_ce_n after 1 edge", int'(ram_ce_n), 0);
    @(posedge clk); #1;
    check("R5", "pfail after 2 edges", int'(pfail), 1);
    check("R4", "ram_ce_n blocked", int'(ram_ce_n), 1);
    check("R4", "dout_en blocked", int'(dout_en), 0);
    drive(17'h00003, 1'b0, 1'b0, 1'b1);
    check("R4", "reg_cs_n blocked", int'(reg_cs_n), 1);
    check("R4", "reg_wr_n blocked", int'(reg_wr_n), 1);
    drive(17'h00040, 1'b0, 1'b1, 1'b0);

    // R7: dropout during hold-off restarts the window
    pwr_good = 1'b1;
    repeat (100) @(posedge clk);
    #1;
    check("R6", "pfail mid hold-off", int'(pfail), 1);
    @(negedge clk);
    pwr_good = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    pwr_good = 1'b1;
    edges_to_release(n);
    check("R7", "release edge after restart", n, int'(REL_EDGE));
    check("R7", "ram_ce_n after release", int'(ram_ce_n), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule